// File: doc/BRIEF.md
# Interrupt Request Recognition Unit

This block decides when a processor core has to leave its instruction stream and service an interrupt. It watches two request lines that may change at any time relative to the clock. The first is a maskable request that is sensed by level and gated by the core's interrupt-enable flag. The second is a non-maskable request that is sensed by edge and is accepted only after a clean low period followed by a sustained high period. Both lines first pass through synchronizer chains.

The core reports each instruction boundary with a one-cycle strobe. At a boundary, a pending non-maskable request is taken at once with a fixed vector of 2 and no bus traffic. A pending and enabled maskable request instead starts two interrupt-acknowledge bus cycles. The bus cycle engine closes each of these cycles with a done strobe. The data returned by the second cycle is the 8-bit vector that is handed to the core, and the data of the first cycle is dropped. Each taken interrupt is reported to the core as a one-cycle take pulse that carries the vector and a flag naming the source.

Top module: `irq_recognizer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ack_req`, `ack_second`, `take_valid`, `irq_pending` and `nmi_pending` are all 0.
- R2: `irq_pending` is 1 exactly when `ien` is 1 and the synchronized `mreq_in` has been high at the last two sampling edges. With default parameters, `mreq_in` driven high with `ien` at 1 makes `irq_pending` read 0 after three rising edges and 1 after the fourth. When `mreq_in` is dropped, `irq_pending` returns to 0, and a later boundary then starts no acknowledge.
- R3: While `ien` is 0, a raised `mreq_in` leaves `irq_pending` at 0, and a boundary strobe starts no acknowledge cycle (`ack_req` stays 0) and gives no `take_valid`.
- R4: When `insn_end` is 1 at an edge while `irq_pending` is 1 and no non-maskable request is pending, `ack_req` is 1 with `ack_second` 0 from the next cycle on. An `ack_done` then moves the block to `ack_second` = 1. An `ack_done` in the second cycle gives, one cycle later, `take_valid` = 1 for one cycle with `take_is_nmi` = 0, and `ack_req` returns to 0.
- R5: `take_vector` on a maskable take equals `ack_data` as sampled with the second `ack_done`. The value on `ack_data` during the first `ack_done` has no effect.
- R6: A boundary strobe while an acknowledge sequence is in progress is ignored: no extra `take_valid` appears and the sequence is not restarted.
- R7: With default parameters, a rise of `nmi_in` after a qualified low period makes `nmi_pending` read 0 after five rising edges and 1 after the sixth, that is, after four synchronized high samples. A high pulse that gives only three synchronized high samples is never recognized.
- R8: A rise of `nmi_in` that follows only three synchronized low samples is not recognized, even if the line then stays high for a long time.
- R9: When `insn_end` is 1 at an edge with `nmi_pending` at 1, the next cycle shows `take_valid` = 1, `take_is_nmi` = 1, `take_vector` = 2, `ack_req` = 0 and `nmi_pending` = 0, whatever the value of `ien`.
- R10: When both requests are pending at a boundary, the non-maskable one is taken and the maskable request remains pending. The maskable request is then served at the following boundary.
- R11: After a non-maskable take, holding `nmi_in` high does not set `nmi_pending` again. A new qualified low period is needed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mreq_in | input | 1 | Maskable request, level sensitive, active high, asynchronous |
| nmi_in | input | 1 | Non-maskable request, edge sensed, active high, asynchronous |
| ien | input | 1 | Interrupt-enable flag from the core |
| insn_end | input | 1 | One-cycle strobe at the last cycle of an instruction |
| ack_done | input | 1 | Bus engine ends the current acknowledge cycle |
| ack_data | input | 8 | Data bus value returned with `ack_done` |
| irq_pending | output | 1 | Enabled maskable request is qualified |
| nmi_pending | output | 1 | Qualified non-maskable request is latched |
| ack_req | output | 1 | Acknowledge bus cycle requested |
| ack_second | output | 1 | Requested acknowledge cycle is the second one |
| take_valid | output | 1 | One-cycle pulse: interrupt taken |
| take_is_nmi | output | 1 | Taken interrupt is the non-maskable one |
| take_vector | output | 8 | Vector of the taken interrupt |

## Verification
The two functions that can fall on the same boundary are the non-maskable take and the start of a maskable acknowledge. The bench provokes this by holding `mreq_in` high until `irq_pending` reads 1, then giving `nmi_in` a qualified rise, and strobing `insn_end` once both flags read 1. It judges the result by requiring, in the cycle after the strobe, a non-maskable take with vector 2 and no `ack_req`, while `irq_pending` still reads 1. A later boundary must then run the full two-cycle acknowledge and deliver the second-cycle data.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants and the acknowledge sequencer state type for the
// interrupt request recognition unit.
package irq_pkg;
    localparam int unsigned VEC_W = 8;
    localparam logic [VEC_W-1:0] NMI_VECTOR = VEC_W'(2);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACK1 = 2'd1,
        SEQ_ACK2 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Multi-stage flip-flop synchronizer for one asynchronous level input.
// Assumes the input may change at any time; the output is the input delayed
// by STAGES rising edges. Reset value is 0 (requests inactive).
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mask_qualifier.sv
// Module mask_qualifier
// Level qualification of the synchronized maskable request: the request
// counts as ready only after it was seen high on QUAL consecutive edges.
// Assumes the input is already synchronous to clk.
module mask_qualifier #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic ready
);
    logic [QUAL-1:0] hist;

    // One history flop per required sample; stage 0 takes the new sample.
    for (genvar g = 0; g < QUAL; g++) begin : g_hist
        if (g == 0) begin : g_first
            // Capture the newest synchronized sample.
            always_ff @(posedge clk) begin
                if (!rst_n) hist[0] <= 1'b0;
                else        hist[0] <= lvl_in;
            end
        end else begin : g_next
            // Age the previous sample by one edge.
            always_ff @(posedge clk) begin
                if (!rst_n) hist[g] <= 1'b0;
                else        hist[g] <= hist[g-1];
            end
        end
    end

    assign ready = &hist;

    AST_READY_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(lvl_in)); // R2
endmodule

// File: rtl/nmi_qualifier.sv
// Module nmi_qualifier
// Edge qualification of the synchronized non-maskable request. A rise is
// accepted only after at least LOW_MIN low samples, and it sets the pending
// latch once the line has also given HIGH_MIN high samples. The latch is
// cleared by accept. Each qualified low period arms exactly one recognition.
// Assumes the input is already synchronous to clk and LOW_MIN, HIGH_MIN >= 1.
module nmi_qualifier #(
    parameter int LOW_MIN  = 4,
    parameter int HIGH_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic accept,
    output logic pending
);
    localparam int MAXC = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_SAT   = CW'(LOW_MIN);
    localparam logic [CW-1:0] LOW_ARM   = CW'(LOW_MIN - 1);
    localparam logic [CW-1:0] HIGH_SAT  = CW'(HIGH_MIN);
    localparam logic [CW-1:0] HIGH_FIRE = CW'(HIGH_MIN - 1);

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;
    logic          armed;
    logic          fire;

    assign fire = lvl_in && armed && (high_cnt == HIGH_FIRE);

    // Count consecutive low and high samples, saturating at their limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else if (lvl_in) begin
            low_cnt <= '0;
            if (high_cnt < HIGH_SAT) high_cnt <= high_cnt + 1'b1;
        end else begin
            high_cnt <= '0;
            if (low_cnt < LOW_SAT) low_cnt <= low_cnt + 1'b1;
        end
    end

    // Arm on a long enough low period; consume the arm on recognition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!lvl_in) begin
            armed <= (low_cnt >= LOW_ARM);
        end else if (fire) begin
            armed <= 1'b0;
        end
    end

    // Pending latch: set on recognition, cleared when the core takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (fire)   pending <= 1'b1;
        else if (accept) pending <= 1'b0;
    end

    AST_NMI_SET_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(lvl_in)); // R7
    AST_NMI_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(accept)); // R9
    AST_NMI_ARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(!lvl_in)); // R8
endmodule

// File: rtl/ack_sequencer.sv
// Module ack_sequencer
// Decides at each instruction boundary which interrupt is taken. A pending
// non-maskable request wins and is reported at once with the fixed vector.
// Otherwise an enabled maskable request runs two acknowledge bus cycles, and
// the vector is captured from the data of the second one. Boundaries that
// arrive during an acknowledge sequence are ignored.
// Assumes ack_done is asserted only while ack_req is high.
module ack_sequencer
    import irq_pkg::*;
#(
    parameter int VW = 8,
    parameter logic [VW-1:0] FIXED_VEC = VW'(2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_end,
    input  logic          nmi_pend,
    input  logic          irq_ok,
    input  logic          ack_done,
    input  logic [VW-1:0] ack_data,
    output logic          nmi_accept,
    output logic          ack_req,
    output logic          ack_second,
    output logic          take_valid,
    output logic          take_is_nmi,
    output logic [VW-1:0] take_vector
);
    seq_state_t state;
    logic       idle;
    logic       start_mask;
    logic       finish_mask;

    assign idle        = (state == SEQ_IDLE);
    assign nmi_accept  = idle && insn_end && nmi_pend;
    assign start_mask  = idle && insn_end && !nmi_pend && irq_ok;
    assign finish_mask = (state == SEQ_ACK2) && ack_done;
    assign ack_req     = !idle;
    assign ack_second  = (state == SEQ_ACK2);

    // Step through idle, first and second acknowledge cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE: if (start_mask) state <= SEQ_ACK1;
                SEQ_ACK1: if (ack_done)   state <= SEQ_ACK2;
                SEQ_ACK2: if (ack_done)   state <= SEQ_IDLE;
                default:                  state <= SEQ_IDLE;
            endcase
        end
    end

    // Present a one-cycle take pulse with the vector and its source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid  <= 1'b0;
            take_is_nmi <= 1'b0;
            take_vector <= '0;
        end else if (nmi_accept) begin
            take_valid  <= 1'b1;
            take_is_nmi <= 1'b1;
            take_vector <= FIXED_VEC;
        end else if (finish_mask) begin
            take_valid  <= 1'b1;
            take_is_nmi <= 1'b0;
            take_vector <= ack_data;
        end else begin
            take_valid  <= 1'b0;
        end
    end

    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(irq_ok)); // R3
    AST_ACK_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(!nmi_pend)); // R10
    AST_MASK_TAKE_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !take_is_nmi) |-> $past(ack_second && ack_done)); // R4
    AST_NMI_TAKE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_is_nmi) |-> (!ack_req && $past(!ack_req))); // R9
    AST_SECOND_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_second) |-> $past(ack_req && ack_done)); // R4
endmodule

// File: rtl/irq_recognizer.sv
// Module irq_recognizer
// Top of the interrupt request recognition unit. Synchronizes both request
// lines, qualifies the maskable level and the non-maskable edge, and hands
// both to the acknowledge sequencer that serves instruction boundaries.
// Assumes insn_end is a one-cycle strobe and ack_done is given only while
// ack_req is high.
module irq_recognizer
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MASK_QUAL    = 2,
    parameter int NMI_LOW_MIN  = 4,
    parameter int NMI_HIGH_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreq_in,
    input  logic             nmi_in,
    input  logic             ien,
    input  logic             insn_end,
    input  logic             ack_done,
    input  logic [VEC_W-1:0] ack_data,
    output logic             irq_pending,
    output logic             nmi_pending,
    output logic             ack_req,
    output logic             ack_second,
    output logic             take_valid,
    output logic             take_is_nmi,
    output logic [VEC_W-1:0] take_vector
);
    logic mreq_sync;
    logic nmi_sync;
    logic mask_ready;
    logic nmi_accept;

    irq_sync #(.STAGES(SYNC_STAGES)) i_sync_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mreq_in),
        .sync_out (mreq_sync)
    );

    irq_sync #(.STAGES(SYNC_STAGES)) i_sync_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi_in),
        .sync_out (nmi_sync)
    );

    mask_qualifier #(.QUAL(MASK_QUAL)) i_mask_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (mreq_sync),
        .ready  (mask_ready)
    );

    nmi_qualifier #(
        .LOW_MIN  (NMI_LOW_MIN),
        .HIGH_MIN (NMI_HIGH_MIN)
    ) i_nmi_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (nmi_sync),
        .accept  (nmi_accept),
        .pending (nmi_pending)
    );

    assign irq_pending = mask_ready && ien;

    ack_sequencer #(
        .VW        (VEC_W),
        .FIXED_VEC (NMI_VECTOR)
    ) i_ack_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_end    (insn_end),
        .nmi_pend    (nmi_pending),
        .irq_ok      (irq_pending),
        .ack_done    (ack_done),
        .ack_data    (ack_data),
        .nmi_accept  (nmi_accept),
        .ack_req     (ack_req),
        .ack_second  (ack_second),
        .take_valid  (take_valid),
        .take_is_nmi (take_is_nmi),
        .take_vector (take_vector)
    );

    AST_PENDING_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ien); // R3
endmodule

// File: tb/test_irq_recognizer.sv
// Directed bench for irq_recognizer: one task per scenario, each checking
// its own results at the ports. Inputs change just after falling edges and
// outputs are sampled there too.
module test_irq_recognizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreq_in = 1'b0;
    logic       nmi_in = 1'b0;
    logic       ien = 1'b0;
    logic       insn_end = 1'b0;
    logic       ack_done = 1'b0;
    logic [7:0] ack_data = 8'h00;
    logic       irq_pending, nmi_pending, ack_req, ack_second;
    logic       take_valid, take_is_nmi;
    logic [7:0] take_vector;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_recognizer i_irq_recognizer (
        .clk(clk), .rst_n(rst_n), .mreq_in(mreq_in), .nmi_in(nmi_in),
        .ien(ien), .insn_end(insn_end), .ack_done(ack_done),
        .ack_data(ack_data), .irq_pending(irq_pending),
        .nmi_pending(nmi_pending), .ack_req(ack_req),
        .ack_second(ack_second), .take_valid(take_valid),
        .take_is_nmi(take_is_nmi), .take_vector(take_vector)
    );

    // Watchdog: an overlong run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boundary();
        insn_end = 1'b1;
        step(1);
        insn_end = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mreq_in = 1'b1;
        nmi_in = 1'b0;
        ien = 1'b1;
        step(4);
        chk("R1 ack_req in reset", int'(ack_req), 0);
        chk("R1 take_valid in reset", int'(take_valid), 0);
        chk("R1 irq_pending in reset", int'(irq_pending), 0);
        chk("R1 nmi_pending in reset", int'(nmi_pending), 0);
        mreq_in = 1'b0;
        rst_n = 1'b1;
        step(1);
        chk("R1 ack_second after reset", int'(ack_second), 0);
        chk("R1 irq_pending after reset", int'(irq_pending), 0);
        step(8);
    endtask

    task automatic t_mask_timing();
        ien = 1'b1;
        mreq_in = 1'b1;
        step(3);
        chk("R2 pending too early", int'(irq_pending), 0);
        step(1);
        chk("R2 pending on fourth edge", int'(irq_pending), 1);
    endtask

    task automatic t_mask_take(input logic [7:0] vec, input string req);
        boundary();
        chk({req, " ack_req after boundary"}, int'(ack_req), 1);
        chk({req, " first cycle not second"}, int'(ack_second), 0);
        ack_done = 1'b1;
        ack_data = ~vec;
        step(1);
        chk("R4 second ack cycle", int'(ack_second), 1);
        chk("R5 no take after first cycle", int'(take_valid), 0);
        ack_data = vec;
        step(1);
        ack_done = 1'b0;
        chk({req, " take_valid"}, int'(take_valid), 1);
        chk({req, " take_is_nmi"}, int'(take_is_nmi), 0);
        chk("R5 vector from second cycle", int'(take_vector), int'(vec));
        chk("R4 ack_req released", int'(ack_req), 0);
        step(1);
        chk("R4 take is one cycle", int'(take_valid), 0);
    endtask

    task automatic t_boundary_in_ack();
        boundary();
        chk("R6 ack started", int'(ack_req), 1);
        insn_end = 1'b1;
        step(2);
        insn_end = 1'b0;
        chk("R6 still first cycle", int'(ack_second), 0);
        chk("R6 no take during ack", int'(take_valid), 0);
        ack_done = 1'b1;
        ack_data = 8'h11;
        step(1);
        ack_data = 8'h3C;
        step(1);
        ack_done = 1'b0;
        chk("R6 single take", int'(take_valid), 1);
        chk("R6 vector", int'(take_vector), 8'h3C);
    endtask

    task automatic t_ien_off();
        ien = 1'b0;
        step(1);
        chk("R3 pending masked", int'(irq_pending), 0);
        boundary();
        chk("R3 no ack", int'(ack_req), 0);
        step(2);
        chk("R3 no ack later", int'(ack_req), 0);
        chk("R3 no take", int'(take_valid), 0);
        ien = 1'b1;
        step(1);
    endtask

    task automatic t_mask_drop();
        mreq_in = 1'b0;
        step(6);
        chk("R2 pending drops", int'(irq_pending), 0);
        boundary();
        chk("R2 no ack after drop", int'(ack_req), 0);
    endtask

    task automatic t_nmi_basic();
        nmi_in = 1'b1;
        step(5);
        chk("R7 nmi too early", int'(nmi_pending), 0);
        step(1);
        chk("R7 nmi recognized", int'(nmi_pending), 1);
        ien = 1'b0;
        boundary();
        chk("R9 take_valid", int'(take_valid), 1);
        chk("R9 take_is_nmi", int'(take_is_nmi), 1);
        chk("R9 vector two", int'(take_vector), 2);
        chk("R9 no ack cycle", int'(ack_req), 0);
        chk("R9 pending cleared", int'(nmi_pending), 0);
        ien = 1'b1;
    endtask

    task automatic t_nmi_hold();
        step(12);
        chk("R11 no retrigger while high", int'(nmi_pending), 0);
    endtask

    task automatic t_nmi_short_low();
        nmi_in = 1'b0;
        step(3);
        nmi_in = 1'b1;
        step(12);
        chk("R8 short low ignored", int'(nmi_pending), 0);
    endtask

    task automatic t_nmi_short_high();
        nmi_in = 1'b0;
        step(6);
        nmi_in = 1'b1;
        step(3);
        nmi_in = 1'b0;
        step(10);
        chk("R7 short high ignored", int'(nmi_pending), 0);
    endtask

    task automatic t_priority();
        mreq_in = 1'b1;
        step(6);
        chk("R10 mask pending", int'(irq_pending), 1);
        nmi_in = 1'b1;
        step(6);
        chk("R10 nmi pending", int'(nmi_pending), 1);
        boundary();
        chk("R10 nmi wins", int'(take_is_nmi), 1);
        chk("R10 nmi take", int'(take_valid), 1);
        chk("R10 no ack on nmi", int'(ack_req), 0);
        chk("R10 mask stays pending", int'(irq_pending), 1);
        step(1);
        t_mask_take(8'hA7, "R10");
        mreq_in = 1'b0;
        nmi_in = 1'b0;
        step(6);
    endtask

    initial begin
        t_reset();
        t_mask_timing();
        t_mask_take(8'h5C, "R4");
        t_ien_off();
        t_mask_take(8'hFF, "R4");
        t_boundary_in_ack();
        t_mask_drop();
        t_nmi_basic();
        t_nmi_hold();
        t_nmi_short_low();
        t_nmi_short_high();
        t_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule